// File: doc/BRIEF.md
# CPU-fed monochrome VGA line shifter

This block produces 640x480 monochrome VGA timing from the same 25 MHz clock that runs the host processor, and turns pixel bytes written by that processor into a one-bit video stream. It has no frame buffer and fetches nothing from memory. The processor supplies every byte of every visible line in real time, one byte for each eight pixel clocks. It is paced by a line interrupt that the block raises during the horizontal sync of each line that precedes a visible line.

A write puts the byte into a holding register. At each eight-pixel boundary inside the visible area, that register is moved into an output shift register, and the shift register sends its most significant bit first. If the processor has not supplied a fresh byte in time, the cell is shown blank and a sticky underrun flag records the miss. The processor acknowledges the interrupt by reading a three-bit status word. The same read also clears the underrun flag. No line interrupts are raised during vertical retrace, which leaves the processor free for other work.

Top module: `vga_beam_shifter`

## Requirements
- R1: A line is H_ACT+H_FP+H_SY+H_BP clocks long. `hsync_o` is low for exactly H_SY clocks, starting H_ACT+H_FP clocks after the first visible pixel of the line, and is high otherwise.
- R2: A frame is V_ACT+V_FP+V_SY+V_BP lines long. `vsync_o` is low for the whole of the V_SY lines that start V_ACT+V_FP lines after the first visible line, and is high otherwise.
- R3: Inside the visible area, `pix_o` shows one bit per clock. Each group of 8 pixels shows the byte taken from the holding register at the start of that group, most significant bit first.
- R4: Outside the H_ACT by V_ACT visible area, `pix_o` is 0 whatever was last loaded.
- R5: If no byte has been written since the previous load, an eight-pixel group shows all zeros and the underrun flag is set. The flag stays set until a status read clears it.
- R6: The line interrupt rises at the first clock of horizontal sync, only on the last line of the frame and on visible lines 0 to V_ACT-2. It never rises at any other time.
- R7: `irq_o` is a level. It stays high until a cycle with `stat_rd_i` high, and that read clears both the pending bit and the underrun flag. A new event in the same cycle as the read wins over the clear.
- R8: The status encoding is `stat_o[2]` = interrupt pending (always equal to `irq_o`), `stat_o[1]` = underrun, and `stat_o[0]` = vertical blank (the line index is V_ACT or more). All outputs follow the line position with a single register stage.
- R9: While `rst_ni` is low, `hsync_o` and `vsync_o` are 1, and `irq_o`, `pix_o` and `stat_o` are 0.
- R10: A write in the same clock as a group load does not feed that group. The group gets the previous byte if one was pending, or zeros with an underrun if none was. The new byte is kept for the next group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel and processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Pixel byte write strobe |
| wr_data_i | input | 8 | Pixel byte, leftmost pixel in bit 7 |
| stat_rd_i | input | 1 | Status read strobe; acknowledges interrupt and underrun |
| stat_o | output | 3 | {pending, underrun, vertical blank} |
| irq_o | output | 1 | Line interrupt, active-high level |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| pix_o | output | 1 | Monochrome pixel |

## Verification
The bench uses a reduced raster and runs one frame with each of five feeding patterns.

- **Starved frame (no writes):** shows that blanking and underrun work when no data arrives.
- **Interrupt-driven feeder:** writes whenever the holding register is empty and acknowledges each interrupt. It shows the clean path, in which the underrun flag clears and stays clear.
- **Two random frames:** sparse random writes mixed with random reads exercise every ordering of late bytes, clears and new events.
- **Collision frame:** writes land exactly on group-load clocks. This separates a design that feeds a same-cycle write straight through from one that defers it to the next group.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W  = $clog2(BYTE_W);

  typedef struct packed {
    logic pend;
    logic und;
    logic vblank;
  } vbs_stat_t;
endpackage

// File: rtl/vbs_timing.sv
module vbs_timing
  import vbs_pkg::*;
#(
  parameter int unsigned H_ACT = 640,
  parameter int unsigned H_FP  = 16,
  parameter int unsigned H_SY  = 96,
  parameter int unsigned H_BP  = 48,
  parameter int unsigned V_ACT = 480,
  parameter int unsigned V_FP  = 10,
  parameter int unsigned V_SY  = 2,
  parameter int unsigned V_BP  = 33
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o,
  output logic irq_set_o,
  output logic act_o,
  output logic hsync_o,
  output logic vsync_o,
  output logic vblank_o
);
  localparam int unsigned H_TOT = H_ACT + H_FP + H_SY + H_BP;
  localparam int unsigned V_TOT = V_ACT + V_FP + V_SY + V_BP;
  localparam int unsigned HW = $clog2(H_TOT);
  localparam int unsigned VW = $clog2(V_TOT);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [HW-1:0] H_VIS  = HW'(H_ACT);
  localparam logic [HW-1:0] HS_BEG = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_ACT + H_FP + H_SY);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [VW-1:0] V_VIS  = VW'(V_ACT);
  localparam logic [VW-1:0] V_PRE  = VW'(V_ACT - 1);
  localparam logic [VW-1:0] VS_BEG = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_ACT + V_FP + V_SY);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic act_c, hs_c, vs_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_q == H_LAST) begin
      h_q <= '0;
      v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  always_comb begin
    act_c     = (h_q < H_VIS) && (v_q < V_VIS);
    load_o    = act_c && (h_q[SEL_W-1:0] == '0);
    hs_c      = !((h_q >= HS_BEG) && (h_q < HS_END));
    vs_c      = !((v_q >= VS_BEG) && (v_q < VS_END));
    // line before each visible line: last frame line, or visible lines but the last
    irq_set_o = (h_q == HS_BEG) && ((v_q == V_LAST) || (v_q < V_PRE));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o    <= 1'b0;
      hsync_o  <= 1'b1;
      vsync_o  <= 1'b1;
      vblank_o <= 1'b0;
    end else begin
      act_o    <= act_c;
      hsync_o  <= hs_c;
      vsync_o  <= vs_c;
      vblank_o <= (v_q >= V_VIS);
    end
  end
endmodule

// File: rtl/vbs_serializer.sv
module vbs_serializer
  import vbs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              load_i,
  input  logic              act_i,
  output logic              pix_o,
  output logic              underrun_o
);
  logic [BYTE_W-1:0] hold_q, shift_q;
  logic              full_q;

  assign underrun_o = load_i && !full_q;
  assign pix_o      = act_i && shift_q[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (wr_en_i) begin
      hold_q <= wr_data_i;  // same-cycle load still takes the old byte
      full_q <= 1'b1;
    end else if (load_i) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shift_q <= '0;
    else if (load_i) shift_q <= full_q ? hold_q : '0;
    else             shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
  end
endmodule

// File: rtl/vbs_status.sv
module vbs_status
  import vbs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      set_i,
  input  logic      und_i,
  input  logic      vblank_i,
  input  logic      rd_i,
  output vbs_stat_t stat_o,
  output logic      irq_o
);
  logic pend_q, und_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      if (set_i)     pend_q <= 1'b1;
      else if (rd_i) pend_q <= 1'b0;
      if (und_i)     und_q  <= 1'b1;
      else if (rd_i) und_q  <= 1'b0;
    end
  end

  assign stat_o = '{pend: pend_q, und: und_q, vblank: vblank_i};
  assign irq_o  = pend_q;
endmodule

// File: rtl/vga_beam_shifter.sv
module vga_beam_shifter
  import vbs_pkg::*;
#(
  parameter int unsigned H_ACT = 640,
  parameter int unsigned H_FP  = 16,
  parameter int unsigned H_SY  = 96,
  parameter int unsigned H_BP  = 48,
  parameter int unsigned V_ACT = 480,
  parameter int unsigned V_FP  = 10,
  parameter int unsigned V_SY  = 2,
  parameter int unsigned V_BP  = 33
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              stat_rd_i,
  output logic [2:0]        stat_o,
  output logic              irq_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              pix_o
);
  logic load, irq_set, act, vblank, und_ev;
  vbs_stat_t stat;

  vbs_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SY(H_SY), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SY(V_SY), .V_BP(V_BP)
  ) u_timing (
    .clk_i, .rst_ni,
    .load_o(load), .irq_set_o(irq_set), .act_o(act),
    .hsync_o, .vsync_o, .vblank_o(vblank)
  );

  vbs_serializer u_ser (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .load_i(load), .act_i(act), .pix_o, .underrun_o(und_ev)
  );

  vbs_status u_stat (
    .clk_i, .rst_ni, .set_i(irq_set), .und_i(und_ev),
    .vblank_i(vblank), .rd_i(stat_rd_i), .stat_o(stat), .irq_o
  );

  assign stat_o = stat;
endmodule

// File: rtl/vbs_checker.sv
module vbs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stat_rd_i,
  input logic [2:0] stat_o,
  input logic       irq_o,
  input logic       hsync_o,
  input logic       pix_o
);
  a_r6_irq_at_hsync_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $fell(hsync_o));

  a_r7_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !stat_rd_i) |=> irq_o);

  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> (!irq_o || $fell(hsync_o)));

  a_r5_underrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[1] && !stat_rd_i) |=> stat_o[1]);

  a_r4_dark_in_vblank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[0] |-> !pix_o);

  a_r4_dark_in_hsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_o |-> !pix_o);

  a_r8_irq_is_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == stat_o[2]);
endmodule

bind vga_beam_shifter vbs_checker u_chk (.*);

// File: tb/vga_beam_shifter_bench.sv
module vga_beam_shifter_bench;
  localparam int HA = 32, HF = 4, HS = 8, HB = 8;
  localparam int VA = 6, VF = 2, VS = 2, VB = 3;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FRAME = HT * VT;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, stat_rd = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] stat;
  logic irq, hs, vs, pix;

  vga_beam_shifter #(.H_ACT(HA), .H_FP(HF), .H_SY(HS), .H_BP(HB),
                     .V_ACT(VA), .V_FP(VF), .V_SY(VS), .V_BP(VB)) u_vga_beam_shifter (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_data_i(wr_data), .stat_rd_i(stat_rd),
    .stat_o(stat), .irq_o(irq), .hsync_o(hs), .vsync_o(vs), .pix_o(pix));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state: current counters and expected register contents
  int mh, mv;
  logic [7:0] m_hold, m_shift;
  logic m_full, m_und, m_pend, m_hs, m_vs, m_act, m_vb;

  function automatic bit is_act(int h, int v); return h < HA && v < VA; endfunction
  function automatic bit exp_hs(int h); return !(h >= HA + HF && h < HA + HF + HS); endfunction
  function automatic bit exp_vs(int v); return !(v >= VA + VF && v < VA + VF + VS); endfunction
  function automatic bit irq_line(int v); return v == VT - 1 || v < VA - 1; endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at h=%0d v=%0d: got %0b expected %0b", tag, mh, mv, got, exp);
    end
  endtask

  task automatic step_model(input logic w, input logic [7:0] d, input logic rd);
    bit load, set, uev;
    load = is_act(mh, mv) && (mh % 8 == 0);
    set  = (mh == HA + HF) && irq_line(mv);
    uev  = load && !m_full;
    if (load) m_shift = m_full ? m_hold : 8'h00;
    else      m_shift = {m_shift[6:0], 1'b0};
    if (w) begin m_hold = d; m_full = 1'b1; end
    else if (load) m_full = 1'b0;
    if (set) m_pend = 1'b1; else if (rd) m_pend = 1'b0;
    if (uev) m_und = 1'b1;  else if (rd) m_und = 1'b0;
    m_hs = exp_hs(mh); m_vs = exp_vs(mv); m_act = is_act(mh, mv); m_vb = (mv >= VA);
    mh++;
    if (mh == HT) begin mh = 0; mv = (mv + 1) % VT; end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240722));
    repeat (3) begin
      @(negedge clk);
      chk("R9 hsync", hs, 1'b1); chk("R9 vsync", vs, 1'b1);
      chk("R9 irq", irq, 1'b0);  chk("R9 pix", pix, 1'b0);
      chk("R9 stat", |stat, 1'b0);
    end
    mh = 0; mv = 0; m_hold = '0; m_shift = '0; m_full = 0; m_und = 0; m_pend = 0;
    m_hs = 1; m_vs = 1; m_act = 0; m_vb = 0;
    rst_ni = 1'b1;
    for (int cyc = 0; cyc < 5 * FRAME; cyc++) begin
      int mode;
      logic w, rd;
      logic [7:0] d;
      mode = cyc / FRAME;
      if (cyc > 0) begin
        @(negedge clk);
        chk("R1 hsync", hs, m_hs);
        chk("R2 vsync", vs, m_vs);
        if (!m_act)         chk("R4 blank pixel", pix, 1'b0);
        else if (mode == 3) chk("R10 deferred write pixel", pix, m_shift[7]);
        else                chk("R3 shifted pixel", pix, m_shift[7]);
        chk("R6 irq", irq, m_pend);
        chk("R7 pending", stat[2], m_pend);
        chk("R5 underrun", stat[1], m_und);
        chk("R8 vblank", stat[0], m_vb);
      end
      d = 8'($urandom);
      case (mode)
        0:       begin w = 0; rd = 0; end
        1:       begin w = !m_full; rd = m_pend; end
        3:       begin w = is_act(mh, mv) && (mh % 8 == 0); rd = ($urandom % 16) == 0; end
        default: begin w = ($urandom % 8) == 0; rd = ($urandom % 16) == 0; end
      endcase
      wr_en = w; wr_data = d; stat_rd = rd;
      step_model(w, d, rd);
    end
    @(negedge clk);
    wr_en = 0; stat_rd = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule